// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache with Selective Invalidation

This block is a small, fully associative cache of 4 KB page translations. Each line holds a virtual page number and the address-space identifier it belongs to, along with a 20-bit physical frame number and three permission bits. A requester presents a virtual page number and an identifier. One cycle later it gets a response that reports a hit or a miss. A hit also carries the frame and the permissions.

On a miss the block raises a request to an external table walker and holds it. The walker answers on a separate refill port, and the block stores the answer in a line it chooses itself. A 32-bit invalidation command can clear every line, or only the lines inside a 4 MB section, or only the lines inside a 16 KB group. The command can also be limited to a single identifier. The identifier field sits at one of two places in the command, set by a 4-identifier or 128-identifier configuration.

Configuration inputs set how many lines are in use, whether replacement rotates, and whether hits can be served while a miss is outstanding.

Top module: `asid_tlb`

## Requirements
- R1: A lookup accepted on a clock edge (lk_valid and lk_ready high) gives rsp_valid high in the next cycle. On a hit, rsp_hit is 1 and rsp_pfn/rsp_perm come from the matching line. On a miss, rsp_hit is 0, and miss_valid rises with miss_vpn/miss_asid equal to the looked-up page and identifier. These outputs hold until a refill is taken.
- R2: A line matches a lookup only when it is valid, its page number equals lk_vpn, and its identifier equals lk_asid over all seven bits.
- R3: A refill (fill_valid while miss_valid) writes the pending page, the pending identifier, fill_pfn and fill_perm into the lowest-numbered invalid active line, when there is one. rsp_perm carries the bits as written: bit 2 read, bit 1 write, bit 0 nonsecure.
- R4: When every active line is valid, a refill with cfg_rr=1 replaces the line named by a rotating pointer. The pointer is 0 after reset, moves to the next line after each use, and wraps after the last active line. A value at or above the active count counts as 0. With cfg_rr=0 the refill replaces line 0.
- R5: cfg_lines gives the number of active lines N. A value of 0 means 1, and a value above the line count means all lines. Lines at index N or higher never hit, and they are invalidated one cycle after N drops below them.
- R6: With flush_valid high, flush_cmd[1:0] sets the address match. 0 matches every line. 2 matches lines whose page bits 19:10 equal flush_cmd[19:10], which is a 4 MB section. 3 matches lines whose page bits 19:2 equal flush_cmd[19:2], which is a 16 KB group. 1 matches nothing. Every matched line becomes invalid after the edge.
- R7: flush_cmd[31]=1 further restricts the flush to lines whose identifier equals the command field. With cfg_asid4=0 that field is bits 30:24 and is compared over 7 bits. With cfg_asid4=1 it is bits 30:29 and is compared with the line identifier's low 2 bits. With bit 31 clear, the identifier plays no part.
- R8: At most one miss is outstanding. While miss_valid is high and cfg_hum=0, lk_ready is low. While miss_valid is high and cfg_hum=1, lk_ready is high only for a lookup that hits.
- R9: A flush and a refill on the same edge apply the flush, discard the refill data, and still clear miss_valid.
- R10: After reset all lines are invalid, lk_ready is high, and rsp_valid and miss_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lines | input | CNT_W | Number of active lines |
| cfg_rr | input | 1 | Rotating replacement enable |
| cfg_hum | input | 1 | Serve hits while a miss is outstanding |
| cfg_asid4 | input | 1 | Identifier field is 2 bits at command bits 30:29 |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_vpn | input | 20 | Virtual page number (address bits 31:12) |
| lk_asid | input | 7 | Lookup identifier |
| rsp_valid | output | 1 | Response for last accepted lookup |
| rsp_hit | output | 1 | Response hit flag |
| rsp_pfn | output | 20 | Physical frame number on a hit |
| rsp_perm | output | 3 | Read, write, nonsecure on a hit |
| miss_valid | output | 1 | Outstanding walk request |
| miss_vpn | output | 20 | Page being walked |
| miss_asid | output | 7 | Identifier being walked |
| fill_valid | input | 1 | Refill from walker |
| fill_pfn | input | 20 | Refill frame number |
| fill_perm | input | 3 | Refill permissions |
| flush_valid | input | 1 | Invalidation command strobe |
| flush_cmd | input | 32 | Invalidation command word |

## Verification
The checker watches properties that hold on every cycle:
- A response appears only after an accepted lookup.
- The walk request stays stable until a refill arrives.
- lk_ready stalls a second miss, and also stalls everything when hit-under-miss is off.
- At most one line ever matches.
- An unrestricted full flush leaves no valid line.
- A flush beside a refill clears the request.
- Lines beyond the active count stay empty.

Which line a refill chooses, how the rotating pointer wraps, and the exact section, group and identifier-field matching can only be shown by the bench scenarios. These scenarios fill the cache, evict lines, flush, and then probe which pages still hit.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 7;
  localparam int PERM_W = 3;
  localparam int CMD_W  = 32;

  typedef struct packed {
    logic              valid;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_line_t;

  // Effective number of active lines: 0 means 1, clamp at the line count.
  function automatic int eff_lines(int cfg, int entries);
    if (cfg == 0) return 1;
    if (cfg > entries) return entries;
    return cfg;
  endfunction

  // Does an invalidation command select this line?
  function automatic logic flush_hit(tlb_line_t ln, logic [CMD_W-1:0] cmd, logic asid4);
    logic va_ok;
    logic id_ok;
    case (cmd[1:0])
      2'd0:    va_ok = 1'b1;
      2'd2:    va_ok = (ln.vpn[19:10] == cmd[19:10]);
      2'd3:    va_ok = (ln.vpn[19:2] == cmd[19:2]);
      default: va_ok = 1'b0;
    endcase
    if (!cmd[31])   id_ok = 1'b1;
    else if (asid4) id_ok = (ln.asid[1:0] == cmd[30:29]);
    else            id_ok = (ln.asid == cmd[30:24]);
    return ln.valid && va_ok && id_ok;
  endfunction
endpackage

// File: rtl/asid_tlb_match.sv
module asid_tlb_match
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 4
) (
  input  tlb_line_t          lines [ENTRIES],
  input  logic [CNT_W-1:0]   active_n,
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ASID_W-1:0]  asid,
  input  logic [CMD_W-1:0]   cmd,
  input  logic               asid4,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] flush_vec,
  output tlb_line_t          hit_line
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = lines[g].valid && (CNT_W'(g) < active_n) &&
                        (lines[g].vpn == vpn) && (lines[g].asid == asid);
    assign flush_vec[g] = flush_hit(lines[g], cmd, asid4);
  end

  always_comb begin
    hit_line = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_line = tlb_line_t'(hit_line | lines[i]);
  end
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [CNT_W-1:0]   active_n,
  input  logic               rr_en,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] ptr_q, ptr_eff, ptr_next, first_free;
  logic             found;

  always_comb begin
    found      = 1'b0;
    first_free = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && (CNT_W'(i) < active_n) && !valid_vec[i]) begin
        found      = 1'b1;
        first_free = IDX_W'(i);
      end
  end

  assign ptr_eff    = (CNT_W'(ptr_q) >= active_n) ? '0 : ptr_q;
  assign ptr_next   = ((CNT_W'(ptr_eff) + CNT_W'(1)) >= active_n) ? '0 : ptr_eff + IDX_W'(1);
  assign victim_idx = found ? first_free : (rr_en ? ptr_eff : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ptr_q <= '0;
    else if (advance && !found && rr_en) ptr_q <= ptr_next;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_lines,
  input  logic              cfg_rr,
  input  logic              cfg_hum,
  input  logic              cfg_asid4,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              miss_valid,
  output logic [VPN_W-1:0]  miss_vpn,
  output logic [ASID_W-1:0] miss_asid,
  input  logic              fill_valid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_valid,
  input  logic [CMD_W-1:0]  flush_cmd
);
  tlb_line_t          lines_q [ENTRIES];
  tlb_line_t          hit_line;
  logic [ENTRIES-1:0] valid_vec, hit_vec, flush_vec;
  logic [CNT_W-1:0]   active_n;
  logic [IDX_W-1:0]   victim_idx;
  logic               pending_q;
  logic [VPN_W-1:0]   miss_vpn_q;
  logic [ASID_W-1:0]  miss_asid_q;

  // named events for the checker
  logic lookup_hit, lk_fire, miss_fire, fill_fire, fill_take;

  assign active_n = CNT_W'(eff_lines(int'(cfg_lines), ENTRIES));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
    assign valid_vec[g] = lines_q[g].valid;
  end

  asid_tlb_match #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_match (
    .lines(lines_q), .active_n(active_n), .vpn(lk_vpn), .asid(lk_asid),
    .cmd(flush_cmd), .asid4(cfg_asid4), .hit_vec(hit_vec),
    .flush_vec(flush_vec), .hit_line(hit_line)
  );

  asid_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .active_n(active_n),
    .rr_en(cfg_rr), .advance(fill_take), .victim_idx(victim_idx)
  );

  assign lookup_hit = |hit_vec;
  assign lk_ready   = !pending_q || (cfg_hum && lookup_hit);
  assign lk_fire    = lk_valid && lk_ready;
  assign miss_fire  = lk_fire && !lookup_hit;
  assign fill_fire  = fill_valid && pending_q;
  assign fill_take  = fill_fire && !flush_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) lines_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (CNT_W'(i) >= active_n)
          lines_q[i].valid <= 1'b0;
        else if (flush_valid && flush_vec[i])
          lines_q[i].valid <= 1'b0;
        else if (fill_take && (victim_idx == IDX_W'(i)))
          lines_q[i] <= '{valid: 1'b1, asid: miss_asid_q, vpn: miss_vpn_q,
                          pfn: fill_pfn, perm: fill_perm};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q   <= 1'b0;
      miss_vpn_q  <= '0;
      miss_asid_q <= '0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_pfn     <= '0;
      rsp_perm    <= '0;
    end else begin
      if (fill_fire)      pending_q <= 1'b0;
      else if (miss_fire) pending_q <= 1'b1;
      if (miss_fire) begin
        miss_vpn_q  <= lk_vpn;
        miss_asid_q <= lk_asid;
      end
      rsp_valid <= lk_fire;
      if (lk_fire) begin
        rsp_hit  <= lookup_hit;
        rsp_pfn  <= lookup_hit ? hit_line.pfn : '0;
        rsp_perm <= lookup_hit ? hit_line.perm : '0;
      end
    end
  end

  assign miss_valid = pending_q;
  assign miss_vpn   = miss_vpn_q;
  assign miss_asid  = miss_asid_q;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               lookup_hit,
  input logic               rsp_valid,
  input logic               miss_valid,
  input logic [19:0]        miss_vpn,
  input logic               fill_valid,
  input logic               flush_valid,
  input logic [31:0]        flush_cmd,
  input logic               cfg_hum,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [CNT_W-1:0]   active_n
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid && lk_ready)); // R1
  AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !fill_valid |=> miss_valid && $stable(miss_vpn)); // R1
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_SECOND_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !lookup_hit |-> !lk_ready); // R8
  AST_NO_HUM_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !cfg_hum |-> !lk_ready); // R8
  AST_FULL_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_cmd[1:0] == 2'b00 && !flush_cmd[31] |=> valid_vec == '0); // R6
  AST_FLUSH_CLEARS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && fill_valid && miss_valid |=> !miss_valid); // R9
  AST_INACTIVE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(active_n) |-> (valid_vec >> active_n) == '0); // R5
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lookup_hit(lookup_hit), .rsp_valid(rsp_valid), .miss_valid(miss_valid),
  .miss_vpn(miss_vpn), .fill_valid(fill_valid), .flush_valid(flush_valid),
  .flush_cmd(flush_cmd), .cfg_hum(cfg_hum), .valid_vec(valid_vec),
  .hit_vec(hit_vec), .active_n(active_n)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int ENTRIES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_lines = 4'd4;
  logic cfg_rr = 1'b1, cfg_hum = 1'b0, cfg_asid4 = 1'b0;
  logic lk_valid = 1'b0, lk_ready;
  logic [19:0] lk_vpn = '0;
  logic [6:0] lk_asid = '0;
  logic rsp_valid, rsp_hit;
  logic [19:0] rsp_pfn;
  logic [2:0] rsp_perm;
  logic miss_valid;
  logic [19:0] miss_vpn;
  logic [6:0] miss_asid;
  logic fill_valid = 1'b0;
  logic [19:0] fill_pfn = '0;
  logic [2:0] fill_perm = '0;
  logic flush_valid = 1'b0;
  logic [31:0] flush_cmd = '0;

  int n_checks = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  asid_tlb #(.ENTRIES(ENTRIES)) u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_lines(cfg_lines), .cfg_rr(cfg_rr),
    .cfg_hum(cfg_hum), .cfg_asid4(cfg_asid4), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
    .rsp_perm(rsp_perm), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
    .miss_asid(miss_asid), .fill_valid(fill_valid), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .flush_valid(flush_valid), .flush_cmd(flush_cmd)
  );

  // reference model
  bit        m_v [ENTRIES];
  bit [19:0] m_vpn [ENTRIES];
  bit [6:0]  m_asid [ENTRIES];
  bit [19:0] m_pfn [ENTRIES];
  bit [2:0]  m_perm [ENTRIES];
  int        m_ptr = 0;
  bit        m_pend = 0;
  bit [19:0] m_mvpn;
  bit [6:0]  m_masid;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_active();
    if (cfg_lines == 0) return 1;
    if (int'(cfg_lines) > ENTRIES) return ENTRIES;
    return int'(cfg_lines);
  endfunction

  function automatic int m_find(bit [19:0] vpn, bit [6:0] asid);
    for (int i = 0; i < m_active(); i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  function automatic bit m_sel(bit [6:0] asid, bit [31:0] cmd);
    if (!cmd[31]) return 1;
    return cfg_asid4 ? (asid[1:0] == cmd[30:29]) : (asid == cmd[30:24]);
  endfunction

  task automatic m_flush(bit [31:0] cmd);
    for (int i = 0; i < ENTRIES; i++) begin
      bit addr_ok;
      case (cmd[1:0])
        2'd0: addr_ok = 1;
        2'd2: addr_ok = (m_vpn[i] >> 10) == 20'(cmd[19:10]);
        2'd3: addr_ok = (m_vpn[i] >> 2) == 20'(cmd[19:2]);
        default: addr_ok = 0;
      endcase
      if (addr_ok && m_sel(m_asid[i], cmd)) m_v[i] = 0;
    end
  endtask

  task automatic m_install(bit [19:0] pfn, bit [2:0] perm);
    int slot = -1;
    for (int i = 0; i < m_active(); i++)
      if (slot < 0 && !m_v[i]) slot = i;
    if (slot < 0) begin
      if (cfg_rr) begin
        slot  = (m_ptr >= m_active()) ? 0 : m_ptr;
        m_ptr = (slot + 1 >= m_active()) ? 0 : slot + 1;
      end else slot = 0;
    end
    m_v[slot] = 1; m_vpn[slot] = m_mvpn; m_asid[slot] = m_masid;
    m_pfn[slot] = pfn; m_perm[slot] = perm;
  endtask

  task automatic do_lookup(input bit [19:0] vpn, input bit [6:0] asid, input string tag);
    int idx;
    bit rdy;
    @(negedge clk);
    lk_valid = 1; lk_vpn = vpn; lk_asid = asid;
    #1;
    idx = m_find(vpn, asid);
    rdy = !m_pend || (cfg_hum && idx >= 0);
    chk({tag, " R8 lk_ready"}, 32'(lk_ready), 32'(rdy));
    @(negedge clk);
    lk_valid = 0;
    #1;
    chk({tag, " R1 rsp_valid"}, 32'(rsp_valid), 32'(rdy));
    if (rdy) begin
      chk({tag, " R2 rsp_hit"}, 32'(rsp_hit), 32'(idx >= 0));
      if (idx >= 0) begin
        chk({tag, " R1 rsp_pfn"}, 32'(rsp_pfn), 32'(m_pfn[idx]));
        chk({tag, " R3 rsp_perm"}, 32'(rsp_perm), 32'(m_perm[idx]));
      end else begin
        m_pend = 1; m_mvpn = vpn; m_masid = asid;
      end
    end
    chk({tag, " R1 miss_valid"}, 32'(miss_valid), 32'(m_pend));
    if (m_pend) begin
      chk({tag, " R1 miss_vpn"}, 32'(miss_vpn), 32'(m_mvpn));
      chk({tag, " R1 miss_asid"}, 32'(miss_asid), 32'(m_masid));
    end
  endtask

  task automatic do_fill(input bit [19:0] pfn, input bit [2:0] perm, input bit fl,
                         input bit [31:0] cmd, input string tag);
    @(negedge clk);
    fill_valid = 1; fill_pfn = pfn; fill_perm = perm;
    flush_valid = fl; flush_cmd = cmd;
    @(negedge clk);
    fill_valid = 0; flush_valid = 0;
    if (fl) m_flush(cmd);
    if (m_pend && !fl) m_install(pfn, perm);
    m_pend = 0;
    #1;
    chk({tag, " R9 miss_valid cleared"}, 32'(miss_valid), 32'd0);
  endtask

  task automatic do_flush(input bit [31:0] cmd);
    @(negedge clk);
    flush_valid = 1; flush_cmd = cmd;
    @(negedge clk);
    flush_valid = 0;
    m_flush(cmd);
  endtask

  task automatic set_cfg(input bit [3:0] ln, input bit rr, input bit hum, input bit a4);
    @(negedge clk);
    cfg_lines = ln; cfg_rr = rr; cfg_hum = hum; cfg_asid4 = a4;
    @(negedge clk);
    for (int i = m_active(); i < ENTRIES; i++) m_v[i] = 0;
  endtask

  task automatic probe(input bit [19:0] vpn, input bit [6:0] asid, input string tag);
    do_lookup(vpn, asid, tag);
    if (m_pend) do_fill(vpn ^ 20'h5A5A5, 3'(vpn[2:0] | 3'b100), 0, 0, tag);
  endtask

  function automatic bit [31:0] mk_cmd(bit [1:0] mode, bit am, bit [6:0] a, bit [19:0] v);
    bit [31:0] c = '0;
    c[1:0] = mode;
    if (mode == 2'd2) c[19:10] = v[19:10];
    if (mode == 2'd3) c[19:2] = v[19:2];
    c[31] = am;
    if (cfg_asid4) c[30:29] = a[1:0];
    else c[30:24] = a;
    return c;
  endfunction

  function automatic bit [19:0] rvpn();
    return {10'($urandom % 3), 8'($urandom % 2), 2'($urandom % 4)};
  endfunction

  function automatic bit [6:0] rasid();
    if (cfg_asid4) return 7'($urandom % 4);
    return ($urandom % 3 == 0) ? 7'd5 : 7'($urandom % 2);
  endfunction

  localparam bit [19:0] PA = 20'h00100, PB = 20'h00101, PC = 20'h00102,
                        PD = 20'h00103, PE = 20'h00400, PF = 20'h00805;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    chk("R10 lk_ready after reset", 32'(lk_ready), 32'd1);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R10 miss_valid after reset", 32'(miss_valid), 32'd0);
    chk("R10 lk_ready", 32'(lk_ready), 32'd1);
    do_lookup(PA, 7'd1, "R10 empty lookup misses");
    do_fill(20'hABCDE, 3'b110, 0, 0, "R3 first fill");
    do_lookup(PA, 7'd1, "R1 hit after fill");
    do_lookup(PA, 7'd2, "R2 other asid misses");
    do_fill(20'h11111, 3'b011, 0, 0, "R3 second fill");
    probe(PB, 7'd1, "R3 fill line2");
    probe(PC, 7'd1, "R3 fill line3");
    // all 4 active lines valid: rotating pointer starts at line 0
    probe(PD, 7'd1, "R4 evict ptr0");
    do_lookup(PA, 7'd1, "R4 evicted page misses");
    do_fill(20'h22222, 3'b101, 0, 0, "R4 evict ptr1");
    do_lookup(PA, 7'd2, "R4 ptr1 victim gone");
    do_fill(20'h33333, 3'b100, 0, 0, "R4 evict ptr2");
    probe(PE, 7'd1, "R4 evict ptr3");
    probe(PF, 7'd1, "R4 wrap to ptr0");
    probe(PD, 7'd1, "R4 wrap check");
    // first invalid line is preferred over pointer
    do_flush(mk_cmd(2'd3, 1, 7'd1, PE));
    do_lookup(PE, 7'd1, "R6 group flushed");
    do_fill(20'h44444, 3'b111, 0, 0, "R3 refill into freed line");
    probe(PF, 7'd1, "R3 other lines kept");
    probe(PD, 7'd1, "R3 other lines kept 2");
    // hit-under-miss off
    do_lookup(20'h00777, 7'd1, "R8 miss pending");
    do_lookup(PE, 7'd1, "R8 stall no hum");
    do_fill(20'h55555, 3'b110, 0, 0, "R8 fill");
    set_cfg(4'd4, 1, 1, 0);
    do_lookup(20'h00778, 7'd1, "R8 hum miss");
    do_lookup(PE, 7'd1, "R8 hum hit served");
    do_lookup(20'h00779, 7'd1, "R8 hum second miss stalls");
    do_fill(20'h66666, 3'b010, 0, 0, "R8 hum fill");
    // flush beside refill
    do_lookup(20'h00900, 7'd3, "R9 miss");
    do_fill(20'h77777, 3'b110, 1, mk_cmd(2'd0, 0, 0, 0), "R9 flush wins");
    do_lookup(20'h00900, 7'd3, "R9 refill discarded");
    do_fill(20'h77777, 3'b110, 0, 0, "R9 refill");
    probe(PA, 7'd1, "R9 after");
    probe(PB, 7'd1, "R9 after2");
    probe(PC, 7'd1, "R9 after3");
    // active lines
    set_cfg(4'd2, 1, 1, 0);
    probe(PA, 7'd1, "R5 shrink2 a");
    probe(PB, 7'd1, "R5 shrink2 b");
    probe(PC, 7'd1, "R5 shrink2 c");
    set_cfg(4'd0, 1, 1, 0);
    probe(PC, 7'd1, "R5 zero means one");
    probe(PB, 7'd1, "R5 zero means one b");
    set_cfg(4'd15, 0, 0, 0);
    for (int k = 0; k < 10; k++) probe(20'h00200 + 20'(k), 7'd2, "R5 clamp fill all");
    probe(20'h00300, 7'd2, "R4 rr off line0");
    probe(20'h00200, 7'd2, "R4 rr off check");
    // flush modes
    do_flush(mk_cmd(2'd1, 0, 0, 0));
    probe(20'h00203, 7'd2, "R6 mode1 flushes nothing");
    do_flush(mk_cmd(2'd2, 0, 0, 20'h00200));
    probe(20'h00205, 7'd2, "R6 section flush");
    do_flush(mk_cmd(2'd0, 1, 7'd5, 0));
    probe(20'h00206, 7'd2, "R7 asid mismatch kept");
    set_cfg(4'd8, 1, 0, 1);
    probe(20'h00500, 7'd1, "R7 a4 fill");
    probe(20'h00501, 7'd2, "R7 a4 fill2");
    do_flush(mk_cmd(2'd0, 1, 7'd1, 0));
    probe(20'h00501, 7'd2, "R7 a4 asid2 kept");
    probe(20'h00500, 7'd1, "R7 a4 asid1 flushed");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 10;
      if (n % 500 == 499)
        set_cfg(4'($urandom % 10), 1'($urandom), 1'($urandom), 1'($urandom));
      if (r < 6 || (r < 8 && !m_pend)) do_lookup(rvpn(), rasid(), "R2 random lookup");
      else if (r < 8) do_fill(20'($urandom), 3'($urandom), 0, 0, "R3 random fill");
      else if (r == 9 && m_pend)
        do_fill(20'($urandom), 3'($urandom), 1,
                mk_cmd(2'($urandom), 1'($urandom), rasid(), rvpn()), "R9 random");
      else do_flush(mk_cmd(2'($urandom), 1'($urandom), rasid(), rvpn()));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule